// File: doc/BRIEF.md
# Serial PHY Management Controller

This block turns one packed 32-bit command word into a single Clause 22 management transaction on a two-wire serial bus (a management clock and a bidirectional data line). Software writes the command word. The block splits it into an operation, a PHY address, a register address and a data field. If the access is valid, it sends the serial frame to an external PHY. For a read, it samples the PHY's reply and puts it back into the low half of the same word.

A configured local PHY address filters the traffic. Accesses to any other address never reach the wire. A read to a foreign address comes back as all ones, and a write to a foreign address is dropped. Operation codes other than Clause 22 read and write finish at once and do nothing.

The management clock comes from the system clock through a parameterised divider. It runs only while a frame is in flight. A busy flag covers each frame, and a one-cycle done pulse marks the end of every accepted command.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write of `wr_data` while idle stores the word, and `rd_data` shows it from the next cycle. The field layout is: bits 31:30 start code, bits 29:28 operation, bits 27:23 PHY address, bits 22:18 register address, bits 15:0 data.
- R2: A Clause 22 write (operation 2'b10) to the configured PHY address sends exactly 64 bits, MSB first, each sampled on a rising MDC edge, in this order:
  - 32 ones;
  - 0 then 1;
  - the operation;
  - the PHY address;
  - the register address;
  - 1 then 0;
  - the 16 data bits of the word.
- R3: A Clause 22 read (operation 2'b11) to the configured PHY address drives the same header. It releases MDIO from the first turnaround bit to the end of the frame and samples 16 data bits on the rising MDC edges. At frame end it replaces only bits 15:0 of the stored word, so bits 31:16 keep the written command.
- R4: A read to a PHY address other than `cfg_phy_addr` produces no MDC edges. From the next cycle the stored word is the written word with bits 15:0 set to 16'hFFFF.
- R5: A write to a PHY address other than `cfg_phy_addr` produces no MDC edges and stores the written word unchanged.
- R6: Operation codes 2'b00 and 2'b01 produce no MDC edges and store the written word unchanged.
- R7: Within a frame, MDC has a period of 2*DIV_HALF system clocks. MDIO changes only while MDC is low, right after a falling edge.
- R8: Between frames and after reset, MDC is low and MDIO is released (`mdio_oe` low). After reset the stored word is zero and busy and done are low.
- R9: `busy` is high from the cycle after launch until the falling MDC edge that ends the last data bit. Writes that arrive while busy leave the stored word and the frame on the wire unchanged.
- R10: Every accepted command produces exactly one `done` pulse, one cycle long. For commands that launch no frame, the pulse comes in the cycle after the write. For frames, it comes when busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_phy_addr | input | 5 | Local PHY address whose accesses are forwarded |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word |
| rd_data | output | 32 | Current contents of the command/data word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value (1 when released) |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data sampled value |

## Verification
The bench plays the PHY. It records the resolved data line on every rising MDC edge and answers reads with a value derived from the register address. Matching writes and matching reads with different payloads test the header order, the turnaround ownership and the replacement of only the low half. Foreign-address reads and writes, and the two non-Clause-22 operation codes, check that the filter produces no clock edges and treats reads and writes differently. A command injected in the middle of a frame tells apart a controller that really ignores writes while busy from one that restarts or overwrites.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam logic [1:0] OP_READ  = 2'b11;
  localparam logic [1:0] OP_WRITE = 2'b10;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;   // first turnaround bit
  localparam int DATA_POS   = 48;   // first data bit

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [1:0]  spare;
    logic [15:0] data;
  } mgmt_word_t;

  function automatic logic is_c22(input logic [1:0] op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_word_t w);
    return {32'hFFFF_FFFF, 2'b01, w.op, w.phy, w.regad, 2'b10, w.data};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          terminal;

  assign terminal  = run && (cnt_q == CW'(DIV_HALF - 1));
  assign rise_tick = terminal && !mdc_q;
  assign fall_tick = terminal && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (terminal) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_read,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [15:0]           rd_word,
  output logic                  frame_end
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IW-1:0]         idx_q;
  logic                  active_q;
  logic                  rd_q;
  logic [15:0]           cap_q;
  logic                  released;

  assign released  = rd_q && (idx_q >= IW'(TA_POS));
  assign mdio_oe   = active_q && !released;
  assign mdio_o    = mdio_oe ? sh_q[FRAME_BITS-1] : 1'b1;
  assign frame_end = active_q && fall_tick && (idx_q == IW'(FRAME_BITS - 1));
  assign rd_word   = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      cap_q    <= '0;
    end else if (load) begin
      sh_q     <= frame;
      idx_q    <= '0;
      active_q <= 1'b1;
      rd_q     <= is_read;
      cap_q    <= '0;
    end else if (active_q) begin
      if (rise_tick && rd_q && (idx_q >= IW'(DATA_POS)))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_tick) begin
        if (frame_end) begin
          active_q <= 1'b0;
        end else begin
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  cfg_phy_addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mgmt_word_t  cmd;
  logic [31:0] word_q;
  logic        busy_q, done_q, rdf_q;
  logic        accept, match, launch, frame_end;
  logic        rise_tick, fall_tick;
  logic [15:0] rd_word;

  assign cmd    = mgmt_word_t'(wr_data);
  assign accept = wr_en && !busy_q;
  assign match  = (cmd.phy == cfg_phy_addr);
  assign launch = accept && match && is_c22(cmd.op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rdf_q  <= 1'b0;
    end else begin
      done_q <= (accept && !launch) || frame_end;
      if (accept) begin
        busy_q <= launch;
        rdf_q  <= (cmd.op == OP_READ);
        if (cmd.op == OP_READ && !match) word_q <= {wr_data[31:16], 16'hFFFF};
        else                             word_q <= wr_data;
      end else if (frame_end) begin
        busy_q <= 1'b0;
        if (rdf_q) word_q[15:0] <= rd_word;
      end
    end
  end

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(launch), .frame(build_frame(cmd)),
    .is_read(cmd.op == OP_READ), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_word(rd_word), .frame_end(frame_end)
  );

  assign rd_data = word_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] rd_data,
  input logic        frame_end,
  input logic        launch
);
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !frame_end) |=> (rd_data == $past(rd_data))); // R9

  AST_MDIO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R7

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (rd_data[31:16] == $past(rd_data[31:16]))); // R3

  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R9
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data),
  .frame_end(frame_end), .launch(launch)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
  localparam int HALF = 10;
  localparam logic [4:0] MYPHY = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic        phy_drive = 1'b1;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl #(.DIV_HALF(HALF)) u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_phy_addr(MYPHY), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .done(done),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_drive)
  );

  // PHY model state
  logic       cap[$];
  int         rises, done_cnt, per_err, edge_err, idle_err;
  int         cyc, last_rise;
  logic       prev_mdc = 1'b0, prev_line = 1'b1;
  logic [4:0] cur_reg = '0;

  function automatic logic [15:0] phy_val(input logic [4:0] r);
    return {8'hC3 ^ {3'b000, r}, 3'b101, r};
  endfunction

  function automatic logic [63:0] line_frame(input logic [31:0] w, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, w[29:28], w[27:23], w[22:18], 2'b10, d};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic line;
    line = mdio_oe ? mdio_o : phy_drive;
    if (rst_n) begin
      if (mdc && !prev_mdc) begin
        cap.push_back(line);
        if (rises > 0 && (cyc - last_rise) != 2 * HALF) per_err++;
        last_rise = cyc;
        rises++;
      end
      if (prev_mdc && !mdc) begin
        if (rises == 47)                     phy_drive = 1'b0;
        else if (rises >= 48 && rises <= 63) phy_drive = phy_val(cur_reg)[63 - rises];
        else                                 phy_drive = 1'b1;
      end
      if (prev_mdc && mdc && line != prev_line) edge_err++;
      if (!busy && (mdc || mdio_oe)) idle_err++;
      if (done) done_cnt++;
    end
    prev_mdc  = mdc;
    prev_line = line;
    cyc++;
  end

  task automatic access(input logic [31:0] word, input logic frame, input logic [31:0] imm,
                        input logic [31:0] fin, input logic [63:0] expf,
                        input logic intrude, input logic [31:0] iword, input string req);
    int n;
    int mism;
    cap.delete();
    rises = 0; done_cnt = 0; per_err = 0; edge_err = 0;
    cur_reg = word[22:18];
    phy_drive = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; wr_data = word;
    @(negedge clk);
    wr_en = 1'b0;
    check(busy == frame, {req, " R9 busy after launch"}, 64'(busy), 64'(frame));
    check(rd_data == imm, {req, " R1 stored word"}, 64'(rd_data), 64'(imm));
    n = 0;
    while (busy) begin
      if (intrude && n == 100) begin wr_en = 1'b1; wr_data = iword; end
      else wr_en = 1'b0;
      @(negedge clk);
      n++;
    end
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check(done_cnt == 1, {req, " R10 done pulses"}, 64'(done_cnt), 64'd1);
    check(rd_data == fin, {req, " final word"}, 64'(rd_data), 64'(fin));
    check(cap.size() == (frame ? 64 : 0), {req, " MDC edge count"},
          64'(cap.size()), frame ? 64'd64 : 64'd0);
    if (frame && cap.size() == 64) begin
      mism = 0;
      foreach (cap[i]) if (cap[i] !== expf[63 - i]) mism++;
      check(mism == 0, {req, " R2 frame bits"}, 64'(mism), 64'd0);
      check(per_err == 0 && edge_err == 0, {req, " R7 MDC period/MDIO edge"},
            64'(per_err + edge_err), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(!busy && !done, "R8 reset busy/done", {busy, done}, 64'd0);
    check(!mdc && !mdio_oe, "R8 reset bus idle", {mdc, mdio_oe}, 64'd0);
    check(rd_data == 32'd0, "R8 reset word", 64'(rd_data), 64'd0);

    // R2 matching writes, two payloads
    w = {2'b01, 2'b10, MYPHY, 5'd4, 2'b00, 16'hA55A};
    access(w, 1'b1, w, w, line_frame(w, 16'hA55A), 1'b0, 32'd0, "R2 write A");
    w = {2'b01, 2'b10, MYPHY, 5'd31, 2'b00, 16'h0F01};
    access(w, 1'b1, w, w, line_frame(w, 16'h0F01), 1'b0, 32'd0, "R2 write B");

    // R3 matching reads
    w = {2'b01, 2'b11, MYPHY, 5'd2, 2'b00, 16'h1234};
    access(w, 1'b1, w, {w[31:16], phy_val(5'd2)}, line_frame(w, phy_val(5'd2)),
           1'b0, 32'd0, "R3 read reg2");
    w = {2'b01, 2'b11, MYPHY, 5'd17, 2'b11, 16'h0000};
    access(w, 1'b1, w, {w[31:16], phy_val(5'd17)}, line_frame(w, phy_val(5'd17)),
           1'b0, 32'd0, "R3 read reg17");

    // R4 foreign read
    w = {2'b01, 2'b11, 5'd9, 5'd1, 2'b00, 16'h0042};
    access(w, 1'b0, {w[31:16], 16'hFFFF}, {w[31:16], 16'hFFFF}, 64'd0,
           1'b0, 32'd0, "R4 foreign read");
    // R5 foreign write
    w = {2'b01, 2'b10, 5'd0, 5'd1, 2'b00, 16'hBEEF};
    access(w, 1'b0, w, w, 64'd0, 1'b0, 32'd0, "R5 foreign write");
    // R6 other operation codes
    w = {2'b00, 2'b00, MYPHY, 5'd5, 2'b00, 16'h7777};
    access(w, 1'b0, w, w, 64'd0, 1'b0, 32'd0, "R6 op00");
    w = {2'b00, 2'b01, MYPHY, 5'd6, 2'b00, 16'h8888};
    access(w, 1'b0, w, w, 64'd0, 1'b0, 32'd0, "R6 op01");

    // R9 write during busy is ignored
    w = {2'b01, 2'b10, MYPHY, 5'd8, 2'b00, 16'hC001};
    access(w, 1'b1, w, w, line_frame(w, 16'hC001), 1'b1,
           {2'b01, 2'b11, MYPHY, 5'd9, 2'b00, 16'h0000}, "R9 intrude");

    check(idle_err == 0, "R8 idle bus every clock", 64'(idle_err), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule